// File: doc/BRIEF.md
# Wired-OR Shared Bus with Hold Register

This block stands in for a shared system bus, such as a backplane that several plug-in cards drive, in a design that has no internal tristate drivers. Each source presents a data word and a drive-enable. The block masks each word with its own enable and merges all the masked words with a bitwise OR. The result is the bus value.

A hold register loads the merged value on every clock edge where at least one source drives. When no source drives and the hold mode input is high, the bus shows the held value. This behaves like a floating bus that remembers its last state. When hold mode is low, an idle bus reads as zero. A separate flag reports contention in any cycle where two or more sources drive at once. During contention the bus still carries the OR of all drivers.

Top module: `wbus_top`

## Requirements
- R1: With exactly one drive-enable high, `bus_o` equals that source's word in the same cycle. Source k uses bit k of `src_drv_i` and bits [k*DW +: DW] of `src_data_i`.
- R2: The data word of a source whose enable is low has no effect on `bus_o`.
- R3: With several enables high, `bus_o` is the bitwise OR of the words of the enabled sources.
- R4: `clash_o` is high in a cycle exactly when two or more bits of `src_drv_i` are high. It is low for zero or one active enable.
- R5: With no enable high and `hold_mode_i` = 1, `bus_o` equals the merged bus value at the last clock edge where any enable was high. This includes a value merged during contention.
- R6: With no enable high and `hold_mode_i` = 0, `bus_o` is all zeros. The hold register still loads on driven edges whatever the mode.
- R7: Reset (`rst_ni` low, asynchronous) clears the held value to zero.
- R8: Source data that changes while no enable is high does not alter the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hold_mode_i | input | 1 | 1: idle bus shows the held value; 0: idle bus reads zero |
| src_data_i | input | N_SRC*DW | Data words of all sources; source k in bits [k*DW +: DW] |
| src_drv_i | input | N_SRC | Drive-enables; bit k belongs to source k |
| bus_o | output | DW | Merged bus value |
| clash_o | output | 1 | Two or more sources drive in this cycle |

## Verification
The only internal state is the hold register. A wrong held value stays hidden while any source drives. It appears on `bus_o` in the first idle cycle with hold mode on, which is one cycle after the last driven edge. The bench therefore follows every driven phase with idle cycles, changes the source data while idle, and switches hold mode during idle. Faults in masking or merging show up at once on `bus_o`, in the same cycle as the stimulus. Single, multiple and masked-garbage patterns catch them there.

// File: rtl/wbus_pkg.sv
package wbus_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_SINGLE = 2'd1,
    BUS_CLASH  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/wbus_gate.sv
module wbus_gate #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic          en_i,
  output logic [DW-1:0] data_o
);
  assign data_o = data_i & {DW{en_i}};
endmodule

// File: rtl/wbus_merge.sv
module wbus_merge #(
  parameter int N_SRC = 4,
  parameter int DW    = 8
) (
  input  logic [N_SRC*DW-1:0] gated_i,
  output logic [DW-1:0]       bus_o
);
  always_comb begin
    bus_o = '0;
    for (int k = 0; k < N_SRC; k++) bus_o = bus_o | gated_i[k*DW +: DW];
  end
endmodule

// File: rtl/wbus_census.sv
module wbus_census
  import wbus_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic [N_SRC-1:0] drv_i,
  output bus_state_e       state_o
);
  localparam int CW = $clog2(N_SRC + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < N_SRC; k++) cnt = cnt + CW'(drv_i[k]);
  end

  always_comb begin
    if (cnt == '0)      state_o = BUS_IDLE;
    else if (cnt == CW'(1)) state_o = BUS_SINGLE;
    else                state_o = BUS_CLASH;
  end
endmodule

// File: rtl/wbus_hold.sv
module wbus_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] held_o
);
  logic [DW-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (load_i) held_q <= bus_i;
  end

  assign held_o = held_q;

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> held_q == $past(bus_i));

  assert_idle_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(held_q));
endmodule

// File: rtl/wbus_top.sv
module wbus_top
  import wbus_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int DW    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hold_mode_i,
  input  logic [N_SRC*DW-1:0] src_data_i,
  input  logic [N_SRC-1:0]    src_drv_i,
  output logic [DW-1:0]       bus_o,
  output logic                clash_o
);
  logic [N_SRC*DW-1:0] gated;
  logic [DW-1:0]       merged;
  logic [DW-1:0]       held;
  bus_state_e          state;
  logic                any_drv;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    wbus_gate #(.DW(DW)) u_gate (
      .data_i(src_data_i[k*DW +: DW]),
      .en_i  (src_drv_i[k]),
      .data_o(gated[k*DW +: DW])
    );
  end

  wbus_merge #(.N_SRC(N_SRC), .DW(DW)) u_merge (
    .gated_i(gated),
    .bus_o  (merged)
  );

  wbus_census #(.N_SRC(N_SRC)) u_census (
    .drv_i  (src_drv_i),
    .state_o(state)
  );

  // keeper load enable: OR of all drive-enables
  assign any_drv = |src_drv_i;

  wbus_hold #(.DW(DW)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(any_drv),
    .bus_i (merged),
    .held_o(held)
  );

  always_comb begin
    if (state != BUS_IDLE) bus_o = merged;
    else if (hold_mode_i)  bus_o = held;
    else                   bus_o = '0;
  end

  assign clash_o = (state == BUS_CLASH);

  assert_no_clash_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_drv_i) |-> !clash_o);

  assert_clash_multi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(src_drv_i) > 1) |-> clash_o);

  assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_drv_i == '0 && !hold_mode_i) |-> bus_o == '0);
endmodule

// File: tb/sim_wbus_top.sv
`timescale 1ns/1ps
module sim_wbus_top;
  localparam int N  = 4;
  localparam int DW = 8;

  typedef struct {
    logic [DW-1:0] bus;
    logic          clash;
    string         tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            hold_mode = 1'b1;
  logic [N*DW-1:0] data = '0;
  logic [N-1:0]    drv = '0;
  logic [DW-1:0]   bus;
  logic            clash;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t q[$];
  event sample_ev;

  logic [DW-1:0] m_held = '0;
  logic [DW-1:0] prev_or = '0;
  logic          prev_any = 1'b0;

  always #2.5 clk = ~clk;

  wbus_top #(.N_SRC(N), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hold_mode_i(hold_mode),
    .src_data_i(data), .src_drv_i(drv), .bus_o(bus), .clash_o(clash)
  );

  task automatic step(input logic [N-1:0] d_en, input logic [N*DW-1:0] d_dat,
                      input logic mode, input string tag);
    exp_t e;
    logic [DW-1:0] or_v;
    int cnt;
    @(negedge clk);
    if (prev_any) m_held = prev_or;
    drv = d_en; data = d_dat; hold_mode = mode;
    or_v = '0; cnt = 0;
    for (int k = 0; k < N; k++)
      if (d_en[k]) begin or_v |= d_dat[k*DW +: DW]; cnt++; end
    e.bus   = (cnt > 0) ? or_v : (mode ? m_held : '0);
    e.clash = (cnt >= 2);
    e.tag   = tag;
    prev_any = (cnt > 0);
    prev_or  = or_v;
    q.push_back(e);
    -> sample_ev;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    drv = '0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    m_held = '0; prev_any = 1'b0; prev_or = '0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(sample_ev);
      #1;
      e = q.pop_front();
      checks++;
      if (bus !== e.bus) begin
        errors++;
        $display("FAIL %s bus actual %h expected %h", e.tag, bus, e.bus);
      end
      checks++;
      if (clash !== e.clash) begin
        errors++;
        $display("FAIL %s clash actual %b expected %b", e.tag, clash, e.clash);
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(4'b0000, 32'hA5A5_A5A5, 1'b1, "R7");          // held cleared by reset
    for (int k = 0; k < N; k++) begin
      step(4'(1 << k), 32'h4433_2211 + 32'(k * 32'h0101_0101), 1'b1, "R1");
    end
    step(4'b0001, 32'hFFFF_FF3C, 1'b1, "R2");           // others' garbage masked
    step(4'b0100, 32'hFF00_FFFF, 1'b1, "R2");
    step(4'b0000, 32'h1234_5678, 1'b1, "R5");           // idle shows last driven
    step(4'b0000, 32'h8765_4321, 1'b1, "R8");           // data moves while idle
    step(4'b0000, 32'h0F0F_0F0F, 1'b0, "R6");
    step(4'b0000, 32'h0F0F_0F0F, 1'b1, "R8");
    step(4'b0011, 32'h0000_1201, 1'b0, "R3");           // loads in mode 0 too
    step(4'b0000, 32'h0000_0000, 1'b1, "R6");
    step(4'b0110, 32'h0040_0800, 1'b1, "R4");
    step(4'b1111, 32'h8040_2010, 1'b1, "R3");
    step(4'b1010, 32'hC000_0300, 1'b1, "R4");
    step(4'b0000, 32'h0000_0000, 1'b1, "R5");           // held OR from contention
    step(4'b1000, 32'h7E00_0000, 1'b1, "R1");
    step(4'b0000, 32'h0000_0000, 1'b0, "R6");
    step(4'b0001, 32'h0000_0099, 1'b1, "R1");
    pulse_reset();
    step(4'b0000, 32'hFFFF_FFFF, 1'b1, "R7");
    for (int i = 0; i < 60; i++) begin
      step(4'($urandom_range(0, 15)), $urandom, 1'($urandom_range(0, 1)), "R3");
      if (i % 5 == 4) step(4'b0000, $urandom, 1'b1, "R5");
    end
    @(negedge clk);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule